// File: doc/BRIEF.md
# USART Bit-Rate and Clock Generator

This block makes the timing strobes for a serial transmitter and receiver. A reloadable down-counter runs on the system clock and divides it by a 12-bit divisor plus one. The result is a base strobe, and the receiver uses that strobe without further division. A free-running post-divide counter counts base strobes and makes the transmit strobe. The ratio is 16 in asynchronous normal speed, 8 in asynchronous double speed and 2 in synchronous operation. Every output is a one-cycle enable in the system clock domain, never a derived clock.

In synchronous operation the direction of the serial clock pin picks the clock source. When the pin is an output, the block is the clock master: it drives the pin with half the base strobe rate and enables the pin driver. When the pin is an input, the block is a slave: the pin passes through a two-stage synchroniser and an edge detector, and a polarity input picks the active edge. Both the transmit and the receive strobe then follow the detected edges. In asynchronous operation the pin is neither driven nor sampled.

Control encoding: `sync_mode_i`=1 selects synchronous operation. `clk_dir_out_i`=1 selects master (it only counts in synchronous operation). `dbl_speed_i`=1 selects double speed (it only counts in asynchronous operation). `fall_edge_i`=1 selects falling edges in slave mode, and 0 selects rising edges.

Top module: `usart_clkgen`

## Requirements
- R1: The down-counter decrements once per system clock. When it is zero it reloads `divisor_i` on the next cycle. A base strobe is present in every cycle in which the counter is zero, so the strobe period is `divisor_i`+1 cycles. A divisor of 0 gives a strobe on every cycle.
- R2: A cycle with `div_lo_wr_i` high makes the counter hold `divisor_i` in the following cycle, whatever value it had. A change of `divisor_i` without the strobe does not disturb a count in progress; the new value is taken at the next natural zero.
- R3: Outside synchronous slave mode, `rx_tick_o` equals the base strobe.
- R4: A 4-bit post-divide counter advances by one on each base strobe and wraps. `tx_tick_o` is high on a base strobe whose counter value, before it advances, has low bits all ones. The low bits checked are 4 bits in asynchronous normal speed (every 16th strobe), 3 bits in double speed (every 8th strobe) and bit 0 in synchronous master (every 2nd strobe).
- R5: In synchronous master mode, `clk_oe_o` is high starting one cycle after the mode is applied. While it is high, `clk_o` equals bit 0 of the post-divide counter, so it toggles on each base strobe.
- R6: In asynchronous modes, `clk_oe_o` is low from the next cycle and `clk_o` is low. Activity on `clk_pin_i` does not change `rx_tick_o` or `tx_tick_o`.
- R7: In synchronous slave mode, `clk_oe_o` is low. A pin level taken at one edge and differing from the level taken at the edge before gives a one-cycle strobe during the second following cycle. With `fall_edge_i`=0 only 0-to-1 changes count; with 1 only 1-to-0 changes count. Both `tx_tick_o` and `rx_tick_o` equal that strobe.
- R8: A cycle with `rst_n` low (synchronous reset) loads the counter with `divisor_i`, clears the post-divide counter and the synchroniser, and drops `clk_oe_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| divisor_i | input | 12 | Divisor value |
| div_lo_wr_i | input | 1 | Strobe marking a write of the divisor's low byte |
| sync_mode_i | input | 1 | 1 = synchronous operation |
| dbl_speed_i | input | 1 | 1 = asynchronous double speed |
| clk_dir_out_i | input | 1 | Serial clock pin direction, 1 = output (master) |
| fall_edge_i | input | 1 | Slave polarity, 1 = falling edges active |
| clk_pin_i | input | 1 | Level read from the serial clock pin |
| tx_tick_o | output | 1 | Transmit bit strobe |
| rx_tick_o | output | 1 | Receiver base strobe |
| clk_o | output | 1 | Level driven onto the serial clock pin |
| clk_oe_o | output | 1 | Pin driver enable |

## Verification
A wrong down-counter value shows on `rx_tick_o` within one divisor period, because the strobe lands in the wrong cycle. A post-divide counter that is out of phase moves `tx_tick_o` and the master `clk_o` level at the next base strobe. A synchroniser that is stuck or too short shifts or drops the slave strobes by a cycle or more, at the next pin edge. The bench runs a behavioural model alongside the design and compares every output in every cycle, so any of these faults shows within a few cycles of its cause.

// File: rtl/usart_clkgen_pkg.sv
package usart_clkgen_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC_NORM,
        MODE_ASYNC_DBL,
        MODE_SYNC_MASTER,
        MODE_SYNC_SLAVE
    } clk_mode_e;

    function automatic clk_mode_e decode_mode(input logic sync_m,
                                              input logic dbl,
                                              input logic dir_out);
        if (!sync_m)
            return dbl ? MODE_ASYNC_DBL : MODE_ASYNC_NORM;
        return dir_out ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
    endfunction

endpackage

// File: rtl/baud_downcnt.sv
module baud_downcnt #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             reload_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } dc_state_t;

    dc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n)
            st_d.cnt = divisor_i;
        else if (reload_i || st_q.cnt == '0)
            st_d.cnt = divisor_i;
        else
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign tick_o = (st_q.cnt == '0);

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> st_q.cnt == $past(divisor_i));

    // R1
    count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload_i && !tick_o) |=> st_q.cnt == $past(st_q.cnt) - 1'b1);

endmodule

// File: rtl/tx_postdiv.sv
module tx_postdiv #(
    parameter int PD_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            base_tick_i,
    input  logic [PD_W-1:0] mask_i,
    output logic            tx_tick_o,
    output logic            phase_o
);
    typedef struct packed {
        logic [PD_W-1:0] cnt;
    } pd_state_t;

    pd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n)
            st_d.cnt = '0;
        else if (base_tick_i)
            st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign tx_tick_o = base_tick_i && ((st_q.cnt & mask_i) == mask_i);
    assign phase_o   = st_q.cnt[0];

    // R4
    pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !base_tick_i |=> $stable(st_q.cnt));

endmodule

// File: rtl/xck_edge_sync.sv
module xck_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic pin_i,
    input  logic fall_i,
    output logic edge_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sy_state_t;

    sy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d = '0;
        end else begin
            st_d.s1 = enable_i ? pin_i : 1'b0;
            st_d.s2 = st_q.s1;
            st_d.s3 = st_q.s2;
        end
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign edge_o = fall_i ? (st_q.s3 & ~st_q.s2) : (st_q.s2 & ~st_q.s3);

    // R7
    edge_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_o && $stable(fall_i)) |=> !edge_o);

    // R6
    idle_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !st_q.s1);

endmodule

// File: rtl/usart_clkgen.sv
module usart_clkgen
    import usart_clkgen_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int PD_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             div_lo_wr_i,
    input  logic             sync_mode_i,
    input  logic             dbl_speed_i,
    input  logic             clk_dir_out_i,
    input  logic             fall_edge_i,
    input  logic             clk_pin_i,
    output logic             tx_tick_o,
    output logic             rx_tick_o,
    output logic             clk_o,
    output logic             clk_oe_o
);
    localparam logic [PD_W-1:0] MASK_NORM = '1;
    localparam logic [PD_W-1:0] MASK_DBL  = MASK_NORM >> 1;
    localparam logic [PD_W-1:0] MASK_SYNC = PD_W'(1);

    typedef struct packed {
        logic oe;
    } top_state_t;

    top_state_t      st_d, st_q;
    clk_mode_e       mode;
    logic            is_slave;
    logic            base_tick;
    logic            ext_edge;
    logic            pd_tick;
    logic            pd_phase;
    logic [PD_W-1:0] pd_mask;

    assign mode     = decode_mode(sync_mode_i, dbl_speed_i, clk_dir_out_i);
    assign is_slave = (mode == MODE_SYNC_SLAVE);

    always_comb begin
        case (mode)
            MODE_ASYNC_NORM: pd_mask = MASK_NORM;
            MODE_ASYNC_DBL:  pd_mask = MASK_DBL;
            default:         pd_mask = MASK_SYNC;
        endcase
    end

    baud_downcnt #(.DIV_W(DIV_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .divisor_i (divisor_i),
        .reload_i  (div_lo_wr_i),
        .tick_o    (base_tick)
    );

    tx_postdiv #(.PD_W(PD_W)) u_pd (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_tick_i (base_tick),
        .mask_i      (pd_mask),
        .tx_tick_o   (pd_tick),
        .phase_o     (pd_phase)
    );

    xck_edge_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (is_slave),
        .pin_i    (clk_pin_i),
        .fall_i   (fall_edge_i),
        .edge_o   (ext_edge)
    );

    always_comb begin
        st_d    = st_q;
        st_d.oe = rst_n && (mode == MODE_SYNC_MASTER);
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign rx_tick_o = is_slave ? ext_edge : base_tick;
    assign tx_tick_o = is_slave ? ext_edge : pd_tick;
    assign clk_oe_o  = st_q.oe;
    assign clk_o     = st_q.oe & pd_phase;

    // R6
    oe_async_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_mode_i |=> !clk_oe_o);

    // R4
    tx_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tick_o && !is_slave) |-> rx_tick_o);

    // R5
    pin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_oe_o |-> !clk_o);

endmodule

// File: tb/sim_usart_clkgen.sv
module sim_usart_clkgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] divisor = 12'd3;
    logic        lo_wr = 1'b0;
    logic        sync_m = 1'b0;
    logic        dbl = 1'b0;
    logic        dir_out = 1'b0;
    logic        fall = 1'b0;
    logic        pin = 1'b0;
    logic        tx_tick, rx_tick, xck, xck_oe;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    int   m_cnt = 3;
    int   m_pd = 0;
    bit   m_oe = 1'b0;
    bit   m_hist[$];

    always #4 clk = ~clk;

    usart_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .divisor_i(divisor), .div_lo_wr_i(lo_wr),
        .sync_mode_i(sync_m), .dbl_speed_i(dbl), .clk_dir_out_i(dir_out),
        .fall_edge_i(fall), .clk_pin_i(pin),
        .tx_tick_o(tx_tick), .rx_tick_o(rx_tick), .clk_o(xck), .clk_oe_o(xck_oe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // one cycle: inputs already driven; compare at mid-cycle, advance model at edge
    task automatic step();
        bit base, slave, edg, t_exp, r_exp, older, newer;
        int mask;
        #1;
        base  = (m_cnt == 0);
        slave = sync_m && !dir_out;
        older = m_hist[0];
        newer = m_hist[1];
        edg   = fall ? (older && !newer) : (newer && !older);
        mask  = sync_m ? 1 : (dbl ? 7 : 15);
        r_exp = slave ? edg : base;
        t_exp = slave ? edg : (base && ((m_pd & mask) == mask));
        if (rst_n) begin
            chk("R1/R2/R3 rx_tick", rx_tick, r_exp);
            chk("R4/R7 tx_tick", tx_tick, t_exp);
            chk("R5/R6 clk_oe", xck_oe, m_oe);
            chk("R5/R6 clk_o", xck, m_oe && m_pd[0]);
        end else begin
            chk("R8 clk_oe in reset", xck_oe, m_oe);
        end
        if (!rst_n) begin
            m_cnt = divisor; m_pd = 0; m_oe = 0;
            m_hist = '{0, 0, 0};
        end else begin
            m_cnt = (lo_wr || m_cnt == 0) ? int'(divisor) : m_cnt - 1;
            if (base) m_pd = (m_pd + 1) % 16;
            m_oe = sync_m && dir_out;
            void'(m_hist.pop_front());
            m_hist.push_back(slave ? pin : 1'b0);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        m_hist = '{0, 0, 0};
        @(negedge clk);
        run(2);
        rst_n = 1'b1;
        // R8: reset state visible right after release
        #1;
        chk("R8 clk_oe after reset", xck_oe, 1'b0);
        chk("R8 clk_o after reset", xck, 1'b0);
        // R1/R4 async normal, divisor 3
        run(140);
        // R2: low-byte write mid count
        divisor = 12'd9;
        run(3);
        lo_wr = 1'b1; step(); lo_wr = 1'b0;
        run(40);
        // R2: divisor change without strobe waits for natural zero
        divisor = 12'd2;
        run(40);
        // R1: divisor 0 gives a strobe every cycle
        divisor = 12'd0; lo_wr = 1'b1; step(); lo_wr = 1'b0;
        run(40);
        // R4 double speed
        divisor = 12'd1;
        dbl = 1'b1;
        run(80);
        // R6 pin toggling in async is ignored
        for (int i = 0; i < 30; i++) begin pin = ~pin; run(2); end
        // R5 synchronous master
        sync_m = 1'b1; dir_out = 1'b1; dbl = 1'b0;
        divisor = 12'd2;
        run(60);
        // R7 slave, rising edges
        dir_out = 1'b0; fall = 1'b0; pin = 1'b0;
        run(5);
        for (int i = 0; i < 20; i++) begin pin = ~pin; run(4); end
        // R7 slave, falling edges
        fall = 1'b1;
        run(3);
        for (int i = 0; i < 20; i++) begin pin = ~pin; run(3); end
        // back to async: oe drops, pin ignored (R6)
        sync_m = 1'b0;
        for (int i = 0; i < 10; i++) begin pin = ~pin; run(3); end
        // R8 reset in mid operation
        sync_m = 1'b1; dir_out = 1'b1;
        run(10);
        rst_n = 1'b0;
        run(2);
        rst_n = 1'b1;
        run(40);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule